// File: doc/BRIEF.md
# Wishbone to Native Memory Port Bridge

This block turns single-beat Wishbone classic bus accesses into transactions on a native memory port whose data width matches the bus. A request is split into a command beat (address, direction, last marker) and then either a write-data beat or a read-data beat. Each beat uses a valid/ready handshake. The bus acknowledge is raised only after the data phase has finished, so a master that waits for the acknowledge before changing its address or data always sees a completed access.

Width conversion belongs to a converter placed after this bridge. To let that converter pack several narrow writes into one wide access, every write command is marked as not last. Every read command is marked as last, so each read travels alone. When the bus cycle signal drops after one or more writes, a one-cycle flush pulse closes whatever write group is still open downstream.

Top module: `wb_mem_bridge`

## Requirements
- R1: While reset is active, and in the first idle cycle after it, the outputs wb_ack_o, cmd_valid_o, wdat_valid_o, rdat_ready_o and flush_o are all 0.
- R2: The cycle after the bridge sees wb_cyc_i and wb_stb_i both high while idle, cmd_valid_o is 1. cmd_addr_o then equals wb_adr_i unchanged, and cmd_we_o equals wb_we_i.
- R3: A read command (cmd_we_o = 0) always carries cmd_last_o = 1.
- R4: A write command (cmd_we_o = 1) always carries cmd_last_o = 0.
- R5: The cycle after a write command is accepted, wdat_valid_o is 1 with wdat_data_o = wb_dat_i and wdat_be_o = wb_sel_i (bit n enables byte n, bits 8n+7..8n). The cycle after that beat is accepted, wdat_valid_o is 0.
- R6: A write is acknowledged: wb_ack_o is 1 in the cycle after the write-data handshake.
- R7: After a read command is accepted, rdat_ready_o is 1 until read data arrives. In the cycle after the read-data handshake, wb_ack_o is 1 and wb_dat_o holds the returned word.
- R8: wb_ack_o stays high for exactly one cycle. At most one of cmd_valid_o, wdat_valid_o, rdat_ready_o and wb_ack_o is 1 at any time, so there is never more than one access in flight.
- R9: If at least one write command has been accepted since the last flush, flush_o is 1 for exactly one cycle, the first cycle in which wb_cyc_i is low. Reads alone never raise flush_o, and it stays 0 while wb_cyc_i is held high between accesses.
- R10: While cmd_valid_o or wdat_valid_o waits with its ready input low, the valid stays 1 and its payload stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Bus write enable |
| wb_adr_i | input | AW | Bus word address |
| wb_sel_i | input | DW/8 | Bus byte selects |
| wb_dat_i | input | DW | Bus write data |
| wb_dat_o | output | DW | Bus read data |
| wb_ack_o | output | 1 | Bus acknowledge |
| cmd_valid_o | output | 1 | Command beat valid |
| cmd_ready_i | input | 1 | Command beat accepted |
| cmd_we_o | output | 1 | Command direction, 1 = write |
| cmd_last_o | output | 1 | Command closes its group |
| cmd_addr_o | output | AW | Command address |
| wdat_valid_o | output | 1 | Write data valid |
| wdat_ready_i | input | 1 | Write data accepted |
| wdat_data_o | output | DW | Write data |
| wdat_be_o | output | DW/8 | Write byte enables |
| rdat_valid_i | input | 1 | Read data valid |
| rdat_ready_o | output | 1 | Read data accepted |
| rdat_data_i | input | DW | Read data |
| flush_o | output | 1 | Close open write group |

## Verification
The assertions check on every cycle that the last marker follows the command direction, that stalled beats hold still, that write data drops right after acceptance, that the acknowledge and the flush are single-cycle pulses, and that only one phase signal is active at a time. They also check that each data handshake is followed by an acknowledge carrying the right read word. The bench sweeps addresses, every byte-select pattern and varied stall lengths against a responder memory. Only these scenarios can show that partial writes merge correctly into stored words, that flush fires once per write group and never after read-only cycles, and what the outputs look like around reset.

// File: rtl/wbmb_pkg.sv
package wbmb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_WDAT = 3'd2,
    ST_RDAT = 3'd3,
    ST_DONE = 3'd4
  } bridge_st_t;
endpackage

// File: rtl/wbmb_rst_sync.sv
module wbmb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wbmb_seq.sv
module wbmb_seq
  import wbmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       we,
  input  logic       cmd_ready,
  input  logic       wdat_ready,
  input  logic       rdat_valid,
  output bridge_st_t state
);
  bridge_st_t state_q;
  bridge_st_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req)        state_d = ST_CMD;
      ST_CMD:  if (cmd_ready)  state_d = we ? ST_WDAT : ST_RDAT;
      ST_WDAT: if (wdat_ready) state_d = ST_DONE;
      ST_RDAT: if (rdat_valid) state_d = ST_DONE;
      ST_DONE:                 state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/wbmb_rdcap.sv
module wbmb_rdcap #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int LANES = DW / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    logic [7:0] lane_d;

    always_comb begin
      lane_d = cap_en ? din[8*g +: 8] : lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign dout[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/wbmb_wgroup.sv
module wbmb_wgroup (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_cmd_acc,
  input  logic cyc,
  output logic flush
);
  logic open_q;
  logic open_d;
  logic fire;

  assign fire = open_q & ~cyc;

  always_comb begin
    open_d = open_q;
    if (fire)       open_d = 1'b0;
    if (wr_cmd_acc) open_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign flush = fire;
endmodule

// File: rtl/wb_mem_bridge.sv
module wb_mem_bridge
  import wbmb_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wb_cyc_i,
  input  logic            wb_stb_i,
  input  logic            wb_we_i,
  input  logic [AW-1:0]   wb_adr_i,
  input  logic [DW/8-1:0] wb_sel_i,
  input  logic [DW-1:0]   wb_dat_i,
  output logic [DW-1:0]   wb_dat_o,
  output logic            wb_ack_o,
  output logic            cmd_valid_o,
  input  logic            cmd_ready_i,
  output logic            cmd_we_o,
  output logic            cmd_last_o,
  output logic [AW-1:0]   cmd_addr_o,
  output logic            wdat_valid_o,
  input  logic            wdat_ready_i,
  output logic [DW-1:0]   wdat_data_o,
  output logic [DW/8-1:0] wdat_be_o,
  input  logic            rdat_valid_i,
  output logic            rdat_ready_o,
  input  logic [DW-1:0]   rdat_data_i,
  output logic            flush_o
);
  localparam int SW = DW / 8;

  logic       rst_n_int;
  bridge_st_t state;
  logic       bus_req;
  logic       rd_take;
  logic       wr_cmd_acc;

  wbmb_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign bus_req = wb_cyc_i & wb_stb_i;

  wbmb_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req        (bus_req),
    .we         (wb_we_i),
    .cmd_ready  (cmd_ready_i),
    .wdat_ready (wdat_ready_i),
    .rdat_valid (rdat_valid_i),
    .state      (state)
  );

  assign cmd_valid_o  = (state == ST_CMD);
  assign cmd_we_o     = wb_we_i;
  assign cmd_last_o   = ~wb_we_i;
  assign cmd_addr_o   = wb_adr_i;

  assign wdat_valid_o = (state == ST_WDAT);
  assign wdat_data_o  = wb_dat_i;
  assign wdat_be_o    = wb_sel_i[SW-1:0];

  assign rdat_ready_o = (state == ST_RDAT);
  assign rd_take      = rdat_ready_o & rdat_valid_i;
  assign wb_ack_o     = (state == ST_DONE);

  wbmb_rdcap #(.DW(DW)) i_rdcap (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .cap_en (rd_take),
    .din    (rdat_data_i),
    .dout   (wb_dat_o)
  );

  assign wr_cmd_acc = cmd_valid_o & cmd_ready_i & wb_we_i;

  wbmb_wgroup i_wgroup (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_cmd_acc (wr_cmd_acc),
    .cyc        (wb_cyc_i),
    .flush      (flush_o)
  );
endmodule

// File: rtl/wbmb_checker.sv
module wbmb_checker #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wb_ack_o,
  input logic [DW-1:0]   wb_dat_o,
  input logic            cmd_valid_o,
  input logic            cmd_ready_i,
  input logic            cmd_we_o,
  input logic            cmd_last_o,
  input logic [AW-1:0]   cmd_addr_o,
  input logic            wdat_valid_o,
  input logic            wdat_ready_i,
  input logic [DW-1:0]   wdat_data_o,
  input logic [DW/8-1:0] wdat_be_o,
  input logic            rdat_valid_i,
  input logic            rdat_ready_o,
  input logic [DW-1:0]   rdat_data_i,
  input logic            flush_o
);
  AST_RD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_we_o) |-> cmd_last_o); // R3
  AST_WR_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_we_o) |-> !cmd_last_o); // R4
  AST_WDAT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat_valid_o && wdat_ready_i) |=> !wdat_valid_o); // R5
  AST_WR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat_valid_o && wdat_ready_i) |=> wb_ack_o); // R6
  AST_RD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rdat_ready_o && rdat_valid_i) |=> (wb_ack_o && wb_dat_o == $past(rdat_data_i))); // R7
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack_o |=> !wb_ack_o); // R8
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid_o, wdat_valid_o, rdat_ready_o, wb_ack_o})); // R8
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o); // R9
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_we_o))); // R10
  AST_WDAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat_valid_o && !wdat_ready_i) |=>
      (wdat_valid_o && $stable(wdat_data_o) && $stable(wdat_be_o))); // R10
endmodule

bind wb_mem_bridge wbmb_checker #(.AW(AW), .DW(DW)) i_wbmb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wb_ack_o     (wb_ack_o),
  .wb_dat_o     (wb_dat_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_we_o     (cmd_we_o),
  .cmd_last_o   (cmd_last_o),
  .cmd_addr_o   (cmd_addr_o),
  .wdat_valid_o (wdat_valid_o),
  .wdat_ready_i (wdat_ready_i),
  .wdat_data_o  (wdat_data_o),
  .wdat_be_o    (wdat_be_o),
  .rdat_valid_i (rdat_valid_i),
  .rdat_ready_o (rdat_ready_o),
  .rdat_data_i  (rdat_data_i),
  .flush_o      (flush_o)
);

// File: tb/test_wb_mem_bridge.sv
module test_wb_mem_bridge;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wb_cyc_i, wb_stb_i, wb_we_i;
  logic [AW-1:0] wb_adr_i;
  logic [SW-1:0] wb_sel_i;
  logic [DW-1:0] wb_dat_i, wb_dat_o;
  logic          wb_ack_o;
  logic          cmd_valid_o, cmd_ready_i, cmd_we_o, cmd_last_o;
  logic [AW-1:0] cmd_addr_o;
  logic          wdat_valid_o, wdat_ready_i;
  logic [DW-1:0] wdat_data_o;
  logic [SW-1:0] wdat_be_o;
  logic          rdat_valid_i, rdat_ready_o;
  logic [DW-1:0] rdat_data_i;
  logic          flush_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [DW-1:0] mem    [16];
  logic [DW-1:0] shadow [16];

  always #10 clk = ~clk;

  wb_mem_bridge #(.AW(AW), .DW(DW)) i_wb_mem_bridge (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return 32'h5A3C0000 ^ (a * 32'h01030507) ^ (s * 32'h00110000);
  endfunction

  task automatic wr(input int a, input logic [SW-1:0] s, input logic [DW-1:0] d,
                    input int cs, input int ds);
    @(negedge clk);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 1;
    wb_adr_i = AW'(a); wb_sel_i = s; wb_dat_i = d;
    @(negedge clk);
    chk("R2 cmd_valid", 32'(cmd_valid_o), 1);
    chk("R2 cmd_addr", 32'(cmd_addr_o), 32'(a));
    chk("R2 cmd_we", 32'(cmd_we_o), 1);
    chk("R4 write last", 32'(cmd_last_o), 0);
    for (int i = 0; i < cs; i++) begin
      @(negedge clk);
      chk("R10 cmd hold", {cmd_valid_o, cmd_addr_o}, {1'b1, AW'(a)});
    end
    cmd_ready_i = 1;
    @(negedge clk);
    cmd_ready_i = 0;
    chk("R5 wdat_valid", 32'(wdat_valid_o), 1);
    chk("R5 wdat_data", wdat_data_o, d);
    chk("R5 wdat_be", 32'(wdat_be_o), 32'(s));
    chk("R8 cmd dropped", 32'(cmd_valid_o), 0);
    for (int i = 0; i < ds; i++) begin
      @(negedge clk);
      chk("R10 wdat hold", {wdat_valid_o, wdat_be_o, wdat_data_o}, {1'b1, s, d});
      chk("R6 no early ack", 32'(wb_ack_o), 0);
    end
    wdat_ready_i = 1;
    @(negedge clk);
    wdat_ready_i = 0;
    for (int b = 0; b < SW; b++) if (wdat_be_o[b]) mem[a][8*b +: 8] = wdat_data_o[8*b +: 8];
    for (int b = 0; b < SW; b++) if (s[b]) shadow[a][8*b +: 8] = d[8*b +: 8];
    chk("R5 wdat dropped", 32'(wdat_valid_o), 0);
    chk("R6 write ack", 32'(wb_ack_o), 1);
    wb_stb_i = 0;
    @(negedge clk);
    chk("R8 ack one cycle", 32'(wb_ack_o), 0);
    chk("R9 no flush in cycle", 32'(flush_o), 0);
  endtask

  task automatic rd(input int a, input int cs, input int ds);
    @(negedge clk);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 0;
    wb_adr_i = AW'(a); wb_sel_i = '1; wb_dat_i = '0;
    @(negedge clk);
    chk("R2 cmd_valid", 32'(cmd_valid_o), 1);
    chk("R2 cmd_addr", 32'(cmd_addr_o), 32'(a));
    chk("R2 cmd_we", 32'(cmd_we_o), 0);
    chk("R3 read last", 32'(cmd_last_o), 1);
    for (int i = 0; i < cs; i++) begin
      @(negedge clk);
      chk("R10 cmd hold", {cmd_valid_o, cmd_addr_o}, {1'b1, AW'(a)});
    end
    cmd_ready_i = 1;
    @(negedge clk);
    cmd_ready_i = 0;
    chk("R7 rdat_ready", 32'(rdat_ready_o), 1);
    chk("R8 no wdat on read", 32'(wdat_valid_o), 0);
    for (int i = 0; i < ds; i++) begin
      @(negedge clk);
      chk("R7 ready held", {rdat_ready_o, wb_ack_o}, 2'b10);
    end
    rdat_valid_i = 1; rdat_data_i = mem[a];
    @(negedge clk);
    rdat_valid_i = 0; rdat_data_i = '0;
    chk("R7 read ack", 32'(wb_ack_o), 1);
    chk("R7 read data", wb_dat_o, shadow[a]);
    wb_stb_i = 0;
    @(negedge clk);
    chk("R8 ack one cycle", 32'(wb_ack_o), 0);
  endtask

  task automatic end_cyc(input bit expect_flush);
    @(negedge clk);
    wb_cyc_i = 0;
    #1;
    chk("R9 flush at cycle end", 32'(flush_o), 32'(expect_flush));
    @(negedge clk);
    chk("R9 flush single", 32'(flush_o), 0);
  endtask

  initial begin
    rst_n = 0;
    wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0;
    wb_adr_i = '0; wb_sel_i = '0; wb_dat_i = '0;
    cmd_ready_i = 0; wdat_ready_i = 0; rdat_valid_i = 0; rdat_data_i = '0;
    for (int i = 0; i < 16; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {27'd0, wb_ack_o, cmd_valid_o, wdat_valid_o, rdat_ready_o, flush_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 idle outputs", {27'd0, wb_ack_o, cmd_valid_o, wdat_valid_o, rdat_ready_o, flush_o}, 0);

    // full-word writes grouped in one bus cycle
    for (int a = 0; a < 8; a++) wr(a, 4'hF, pat(a, 15), a % 3, (a + 1) % 3);
    end_cyc(1);
    // every byte-select pattern, one bus cycle each
    for (int a = 0; a < 4; a++)
      for (int s = 1; s < 16; s++) begin
        wr(a, SW'(s), ~pat(a, s), s % 3, (a + s) % 3);
        end_cyc(1);
      end
    // read-only cycle: no flush
    for (int a = 0; a < 8; a++) rd(a, (a + 2) % 3, a % 3);
    end_cyc(0);
    // mixed: a read then a write in one cycle, then single reads
    rd(5, 0, 0);
    wr(9, 4'h6, pat(9, 6), 1, 0);
    end_cyc(1);
    for (int a = 0; a < 16; a++) begin
      rd(a, 0, 1);
      end_cyc(0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule